// File: doc/BRIEF.md
# Page Commit Engine

This block gathers the data bytes of one write transaction aimed at a 2048-byte nonvolatile array and commits them as a single page. A serial front-end hands it three kinds of strobe: a start strobe with an 11-bit starting address, a byte strobe with one data byte, and a stop strobe. The upper seven address bits pick one 16-byte page. The lower four bits are the position inside that page where the first byte goes. That position advances by one after each accepted byte and wraps inside the page. The bytes and a per-position enable flag are held in a 16-entry buffer.

Nothing reaches the array while bytes are arriving. A stop that finds at least one buffered byte starts a timed internal write cycle. The busy flag is high for exactly `WRITE_CYCLES` clocks, and every enabled byte lands in the array on the clock edge where busy drops. While busy is high, every strobe is ignored. The array is a plain register memory inside the block, and a combinational read port exposes it.

If a byte strobe comes in the same cycle as a start or a stop, the byte is dropped. A start that comes while bytes are already being collected discards them and begins a fresh transaction.

Top module: `page_commit_engine`

## Requirements
- R1: The array holds 2048 bytes addressed by 11 bits; `rdData` combinationally returns the byte stored at `rdAddr`, including the highest address 0x7FF.
- R2: A start strobe while idle latches bits [10:4] of `startAddr` as the page and bits [3:0] as the first write position.
- R3: Each accepted byte is buffered at the current position, after which only the 4-bit position advances by one, wrapping from 15 to 0, while the page bits stay fixed.
- R4: When more than 16 bytes arrive before stop, the position wraps and a later byte replaces the earlier byte buffered at the same position.
- R5: The array keeps its old contents while bytes are being collected and during the whole busy window.
- R6: A stop with at least one buffered byte raises `busy` on the next clock; `busy` stays high for exactly `WRITE_CYCLES` clocks, and the buffered bytes are written on the edge where it falls.
- R7: Start, byte and stop strobes that arrive while `busy` is high are ignored and do not lengthen the cycle.
- R8: Only positions that received a byte are written; the other 15-or-fewer locations of the page keep their old contents.
- R9: A stop with no buffered byte starts no write cycle: `busy` stays low and the array is unchanged.
- R10: A synchronous `rst` clears the buffer enables, the position counter and `busy`, so a transaction being collected or a write cycle still counting is dropped without touching the array.
- R11: Byte strobes outside a transaction (before any start, or after a stop) are ignored.
- R12: A start while bytes are being collected discards them and begins a new transaction at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Start strobe; begins a transaction |
| startAddr | input | 11 | Starting byte address, sampled with `startValid` |
| byteValid | input | 1 | Data byte strobe |
| byteData | input | 8 | Data byte, sampled with `byteValid` |
| stopValid | input | 1 | Stop strobe; requests the commit |
| rdAddr | input | 11 | Read port address |
| rdData | output | 8 | Array contents at `rdAddr` |
| busy | output | 1 | High while the internal write cycle runs |

## Verification
The hardest case to reach from the ports is a strobe that arrives in the middle of a running write cycle. A stray start, byte or stop must be dropped, and the cycle must still end on time. To produce it, the driver counts busy clocks itself and injects those strobes at fixed counts inside the window. It then checks that busy still lasts exactly the configured length, and that a later stop without a start raises nothing. The array must also be seen to hold still during the window. So on every commit the bench queues reads of the page's old values, and the monitor consumes them while busy is still high.

// File: rtl/pce_pkg.sv
package pce_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic loadStart;  // latch page/position, drop pending bytes
    logic takeByte;   // store byte at current position, advance
    logic commit;     // copy enabled lanes into the array
  } pceStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_WRITE
  } pceState_e;

endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int WRITE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startValid,
  input  logic        byteValid,
  input  logic        stopValid,
  input  logic        anyPending,
  output pceStrobes_t strobes,
  output logic        busy
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(WRITE_CYCLES - 1);

  pceState_e        state, nextState;
  logic [CNT_W-1:0] cycleCnt;

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (!rst) begin
      unique case (state)
        ST_IDLE: begin
          if (startValid) begin
            strobes.loadStart = 1'b1;
            nextState         = ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (stopValid) begin
            nextState = anyPending ? ST_WRITE : ST_IDLE;
          end else if (startValid) begin
            strobes.loadStart = 1'b1;
          end else if (byteValid) begin
            strobes.takeByte = 1'b1;
          end
        end
        ST_WRITE: begin
          if (cycleCnt == LAST_COUNT) begin
            strobes.commit = 1'b1;
            nextState      = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_WRITE && nextState == ST_WRITE)
        cycleCnt <= cycleCnt + 1'b1;
      else
        cycleCnt <= '0;
    end
  end

  assign busy = (state == ST_WRITE);

endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pceStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              anyPending
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PAGE_W-1:0] pageSel;
  logic [OFF_W-1:0]  position;
  logic [7:0]        laneData [PAGE_BYTES];
  logic              laneEn   [PAGE_BYTES];
  logic [7:0]        storage  [DEPTH];

  // Page and in-page position
  always_ff @(posedge clk) begin
    if (rst) begin
      pageSel  <= '0;
      position <= '0;
    end else if (strobes.loadStart) begin
      pageSel  <= startAddr[ADDR_W-1:OFF_W];
      position <= startAddr[OFF_W-1:0];
    end else if (strobes.takeByte) begin
      position <= position + 1'b1;
    end
  end

  // One buffer lane per page position
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst) begin
        laneEn[g]   <= 1'b0;
        laneData[g] <= '0;
      end else if (strobes.loadStart || strobes.commit) begin
        laneEn[g] <= 1'b0;
      end else if (strobes.takeByte && position == OFF_W'(g)) begin
        laneEn[g]   <= 1'b1;
        laneData[g] <= byteData;
      end
    end
  end

  always_comb begin
    anyPending = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) anyPending = anyPending | laneEn[i];
  end

  // Behavioural array, updated only by commit
  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (laneEn[i]) storage[{pageSel, OFF_W'(i)}] <= laneData[i];
      end
    end
  end

  assign rdData = storage[rdAddr];

endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import pce_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              stopValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy
);

  pceStrobes_t strobes;
  logic        anyPending;

  pce_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .startValid(startValid),
    .byteValid (byteValid),
    .stopValid (stopValid),
    .anyPending(anyPending),
    .strobes   (strobes),
    .busy      (busy)
  );

  pce_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .startAddr (startAddr),
    .byteData  (byteData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .anyPending(anyPending)
  );

endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
  parameter int ADDR_W       = 11,
  parameter int WRITE_CYCLES = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              stopValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              busy
);

  localparam int BC_W = $clog2(WRITE_CYCLES + 2);

  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busyCnt <= '0;
    else              busyCnt <= busyCnt + 1'b1;
  end

  // R6: busy only starts from a stop
  assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stopValid));

  // R6, R7: busy window has exactly the configured length
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busyCnt == BC_W'(WRITE_CYCLES));

  // R7: strays cannot stretch the window
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> busyCnt < BC_W'(WRITE_CYCLES));

  // R5: array content moves only on the edge where busy falls
  assert_array_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($stable(rdAddr) && !$fell(busy)) |-> $stable(rdData));

  // R10: reset clears busy
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !busy);

endmodule

bind page_commit_engine pce_checker #(
  .ADDR_W      (ADDR_W),
  .WRITE_CYCLES(WRITE_CYCLES)
) uChecker (
  .clk      (clk),
  .rst      (rst),
  .stopValid(stopValid),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .busy     (busy)
);

// File: tb/page_commit_engine_test.sv
module page_commit_engine_test;

  localparam int WC = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startValid = 1'b0;
  logic [10:0] startAddr = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        stopValid = 1'b0;
  logic [10:0] rdAddr = '0;
  logic [7:0]  rdData;
  logic        busy;

  always #2 clk = ~clk;

  page_commit_engine #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst(rst), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .stopValid(stopValid),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [10:0] addr;
    logic [7:0]  data;
    string       req;
  } expect_t;

  expect_t     expQ[$];
  logic [7:0]  refMem [2048];
  logic [7:0]  pend   [16];
  logic [15:0] pendEn = '0;
  logic [6:0]  mPage = '0;
  logic [3:0]  mOff = '0;
  bit          mOpen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected array contents and compares at the read port
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expect_t e;
        e = expQ.pop_front();
        rdAddr = e.addr;
        #1;
        check(rdData === e.data, e.req, $sformatf("read @%0h", e.addr), rdData, e.data);
      end
    end
  end

  task automatic pushPage(input logic [6:0] page, input string req);
    for (int i = 0; i < 16; i++) begin
      expect_t e;
      e.addr = {page, 4'(i)};
      e.data = refMem[{page, 4'(i)}];
      e.req  = req;
      expQ.push_back(e);
    end
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic startTx(input logic [10:0] a);
    @(negedge clk);
    startValid = 1'b1;
    startAddr  = a;
    @(negedge clk);
    startValid = 1'b0;
    if (!busy) begin
      mPage  = a[10:4];
      mOff   = a[3:0];
      pendEn = '0;
      mOpen  = 1;
    end
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = d;
    @(negedge clk);
    byteValid = 1'b0;
    if (mOpen) begin
      pend[mOff]   = d;
      pendEn[mOff] = 1'b1;
      mOff         = mOff + 1'b1;
    end
  endtask

  // Stop, then follow the busy window; poke injects strays during it
  task automatic stopTx(input bit poke, input string req);
    bit commit;
    int n;
    commit = mOpen && (pendEn != 0);
    mOpen  = 0;
    drain();
    @(negedge clk);
    stopValid = 1'b1;
    @(negedge clk);
    stopValid = 1'b0;
    check(busy === commit, req, "busy after stop", busy, commit);
    if (commit) begin
      pushPage(mPage, "R5");  // old contents must be visible during busy
      n = 0;
      while (busy === 1'b1 && n < WC + 10) begin
        n++;
        if (poke) begin
          if (n == 3) begin startValid = 1'b1; startAddr = 11'h050; end
          if (n == 4) begin startValid = 1'b0; byteValid = 1'b1; byteData = 8'hEE; end
          if (n == 5) begin byteValid = 1'b0; stopValid = 1'b1; end
          if (n == 6) stopValid = 1'b0;
        end
        @(negedge clk);
      end
      check(n == WC, poke ? "R7" : "R6", "busy length", n, WC);
      for (int i = 0; i < 16; i++)
        if (pendEn[i]) refMem[{mPage, 4'(i)}] = pend[i];
      pendEn = '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(busy === 1'b0, req, "busy stays low", busy, 0);
      end
    end
    drain();
  endtask

  task automatic seedPage(input logic [6:0] page, input logic [7:0] base);
    startTx({page, 4'h0});
    for (int i = 0; i < 16; i++) sendByte(base + 8'(i));
    stopTx(0, "R6");
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst    = 1'b0;
    mOpen  = 0;
    pendEn = '0;
    check(busy === 1'b0, "R10", "busy after reset", busy, 0);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10", "busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R10", "busy after reset release", busy, 0);

    // R1, R3, R6: full pages including the lowest and highest
    seedPage(7'h00, 8'h20);
    pushPage(7'h00, "R1"); drain();
    seedPage(7'h7F, 8'hC0);
    pushPage(7'h7F, "R1"); drain();
    seedPage(7'h05, 8'h10);
    pushPage(7'h05, "R3"); drain();

    // R3: position wraps inside the page
    seedPage(7'h2F, 8'h40);
    startTx(11'h2FD);
    for (int i = 0; i < 5; i++) sendByte(8'hA0 + 8'(i));
    stopTx(0, "R3");
    pushPage(7'h2F, "R3"); drain();

    // R4: 20 bytes, first four positions overwritten
    seedPage(7'h10, 8'h00);
    startTx(11'h100);
    for (int i = 0; i < 20; i++) sendByte(8'h60 + 8'(i));
    stopTx(0, "R4");
    pushPage(7'h10, "R4"); drain();

    // R8: partial write keeps neighbours
    startTx(11'h056);
    sendByte(8'h5A); sendByte(8'h5B); sendByte(8'h5C);
    stopTx(0, "R8");
    pushPage(7'h05, "R8"); drain();

    // R2: start in the middle of the top page, single byte
    startTx(11'h7F9);
    sendByte(8'h3C);
    stopTx(0, "R2");
    pushPage(7'h7F, "R2"); drain();

    // R9: stop with nothing buffered
    startTx(11'h050);
    stopTx(0, "R9");
    pushPage(7'h05, "R9"); drain();

    // R11: byte with no transaction open, then a stop
    sendByte(8'h99);
    stopTx(0, "R11");
    pushPage(7'h05, "R11"); drain();

    // R7: strays during busy are dropped
    startTx(11'h058);
    sendByte(8'h71); sendByte(8'h72);
    stopTx(1, "R7");
    sendByte(8'h98);
    stopTx(0, "R7");
    pushPage(7'h05, "R7"); drain();

    // R12: restart discards the first transaction's bytes
    seedPage(7'h30, 8'h80);
    seedPage(7'h31, 8'h90);
    startTx(11'h300);
    sendByte(8'hAA);
    startTx(11'h310);
    sendByte(8'hBB);
    stopTx(0, "R12");
    pushPage(7'h30, "R12");
    pushPage(7'h31, "R12"); drain();

    // R10: reset while collecting
    startTx(11'h050);
    sendByte(8'hD1); sendByte(8'hD2);
    doReset();
    stopTx(0, "R10");
    pushPage(7'h05, "R10"); drain();

    // R10: reset in the middle of a write cycle
    startTx(11'h310);
    sendByte(8'hE1);
    mOpen = 0;
    @(negedge clk);
    stopValid = 1'b1;
    @(negedge clk);
    stopValid = 1'b0;
    repeat (5) @(negedge clk);
    check(busy === 1'b1, "R10", "busy before reset", busy, 1);
    doReset();
    pushPage(7'h31, "R10"); drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule